// File: doc/BRIEF.md
# Reclaimability Checker with Stack-Snapshot Hash Lookup

This block decides the fate of a heap object whose reference count may have reached zero. It receives the object's header pointer, as a high and a low 16-bit half, and its header status word. Any pending decrement has already been applied to that word. The block returns one of three dispositions: continue, reclaim or finalize.

An object that might still be referenced from a stack is not freed. It is handed to the zero-count table through an append handshake, and the status word is returned with its in-table bit set.

To decide whether a stack reference is possible, the block hashes the pointer into a 12-bit index and a residue. It reads one entry of an external 4096-entry snapshot table through a read port with a fixed one-cycle latency, and compares that entry with the residue. If the append reports that the table is full, the block raises trap code 4 instead of giving a disposition.

Top module: `reclaim_checker`

## Requirements
- R1: The disposition encoding is continue = 0, reclaim = 1 and finalize = 2. `done_o` is high for exactly one cycle per accepted `start_i`. The results stay stable until the next start.
- R2: The status word layout is: bits 6:1 reference count, bit 0 overflowed, bit 15 in-table, bit 14 maybe-on-stack, bit 7 finalizable. If the count is nonzero, or the overflowed bit is set, or the in-table bit is set, the result is continue with no table read, no append and `changed_o` = 0. `status_o` equals the input, and `done_o` rises in the cycle right after the start. This takes priority over the maybe-on-stack bit.
- R3: Otherwise, if the maybe-on-stack bit is set, one append is requested with no table read. The result is continue with `changed_o` = 1 and `status_o` = input with bit 15 set.
- R4: Otherwise exactly one table read is issued. Its index is ((lo >> 1) XOR residue) AND 0xFFF, where residue = ((hi << 3) OR (lo >> 13)) truncated to 16 bits. The result is available two cycles after the start when no append follows.
- R5: A table entry equal to the residue requests an append and yields continue with `changed_o` = 1.
- R6: A table entry of 0xFFFF matches any pointer, with the same outcome as R5.
- R7: A table entry of 0x8000 marks an empty slot and never matches a residue of 15 bits or fewer. A non-matching entry yields reclaim when bit 7 is clear.
- R8: A non-matching entry with bit 7 set yields finalize. In both R7 and R8, `changed_o` = 0 and `status_o` equals the input.
- R9: If the append is acknowledged with `app_full_i` high, `trap_o` = 1, `trap_code_o` = 4 and `changed_o` = 0.
- R10: `app_req_o` stays high until `app_ack_i` arrives. The result follows one cycle after the acknowledge.
- R11: After reset, `done_o`, `tbl_rd_o` and `app_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check; accepted when idle |
| ptr_hi_i | input | 16 | Header pointer, high half |
| ptr_lo_i | input | 16 | Header pointer, low half |
| status_i | input | 16 | Header status word |
| tbl_rd_o | output | 1 | Snapshot table read strobe |
| tbl_idx_o | output | 12 | Snapshot table index |
| tbl_data_i | input | 16 | Table entry, valid the cycle after the read |
| app_req_o | output | 1 | Zero-count-table append request |
| app_ack_i | input | 1 | Append acknowledge |
| app_full_i | input | 1 | Table full, qualified by ack |
| done_o | output | 1 | Result valid pulse |
| disp_o | output | 2 | Disposition |
| changed_o | output | 1 | Status word was modified |
| status_o | output | 16 | Updated status word |
| trap_o | output | 1 | Trap instead of disposition |
| trap_code_o | output | 3 | Trap code |

## Verification
The bench targets the priority of the early-continue test over the maybe-on-stack test. A design that got this wrong would append an object that is already in the table. It hashes pointers whose low half has bits 15:13 set, so a residue built from the wrong bits or shifts would read the wrong index. It also places a near-miss residue at the right index, which catches a comparator that ignores the low bit. Empty and wildcard entries are exercised, so a design that treats 0x8000 as a match, or ignores 0xFFFF, returns the wrong disposition. A delayed acknowledge and a full-table acknowledge check that the request is held and that trap code 4 replaces a marked status word.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 12;
  localparam int BIT_IN_TBL = 15;
  localparam int BIT_STACK  = 14;
  localparam int BIT_FINAL  = 7;
  localparam int RC_MSB     = 6;
  localparam int RC_LSB     = 1;
  localparam int BIT_OVF    = 0;
  localparam logic [WORD_W-1:0] ENTRY_WILD = '1;
  localparam logic [2:0] TRAP_FULL = 3'd4;
  typedef enum logic [1:0] {
    DISP_CONT    = 2'd0,
    DISP_RECLAIM = 2'd1,
    DISP_FINAL   = 2'd2
  } disp_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_COMPARE, ST_APPEND, ST_DONE
  } state_e;
endpackage

// File: rtl/rc_hash.sv
module rc_hash #(
  parameter int WORD_W = reclaim_pkg::WORD_W,
  parameter int IDX_W  = reclaim_pkg::IDX_W,
  parameter int HI_SHL = 3,
  parameter int LO_SHR = 13
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  output logic [WORD_W-1:0] residue_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [WORD_W-1:0] mix;
  always_comb begin
    residue_o = (hi_i << HI_SHL) | (lo_i >> LO_SHR);
    mix       = (lo_i >> 1) ^ residue_o;
    idx_o     = mix[IDX_W-1:0];
  end
endmodule

// File: rtl/rc_status_class.sv
module rc_status_class #(
  parameter int RC_W = 6
) (
  input  logic [RC_W-1:0] count_i,
  input  logic            ovf_i,
  input  logic            in_tbl_i,
  input  logic            stack_i,
  output logic            busy_o,
  output logic            need_append_o
);
  always_comb begin
    busy_o        = (|count_i) | ovf_i | in_tbl_i;
    need_append_o = !busy_o && stack_i;
  end
endmodule

// File: rtl/rc_entry_match.sv
module rc_entry_match #(
  parameter int WORD_W = reclaim_pkg::WORD_W,
  parameter bit WILD_EN = 1'b1
) (
  input  logic [WORD_W-1:0] entry_i,
  input  logic [WORD_W-1:0] residue_i,
  output logic              match_o
);
  generate
    if (WILD_EN) begin : g_wild
      assign match_o = (entry_i == residue_i) || (entry_i == reclaim_pkg::ENTRY_WILD);
    end else begin : g_plain
      assign match_o = (entry_i == residue_i);
    end
  endgenerate
endmodule

// File: rtl/reclaim_checker.sv
module reclaim_checker
  import reclaim_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  ptr_hi_i,
  input  logic [W-1:0]  ptr_lo_i,
  input  logic [W-1:0]  status_i,
  output logic          tbl_rd_o,
  output logic [IW-1:0] tbl_idx_o,
  input  logic [W-1:0]  tbl_data_i,
  output logic          app_req_o,
  input  logic          app_ack_i,
  input  logic          app_full_i,
  output logic          done_o,
  output logic [1:0]    disp_o,
  output logic          changed_o,
  output logic [W-1:0]  status_o,
  output logic          trap_o,
  output logic [2:0]    trap_code_o
);
  localparam int RC_W = RC_MSB - RC_LSB + 1;

  state_e         state_q;
  logic [W-1:0]   stat_q;
  logic [W-1:0]   res_q;
  logic [IW-1:0]  idx_q;
  disp_e          disp_q;
  logic           chg_q, trap_q;

  logic [W-1:0]   res_c;
  logic [IW-1:0]  idx_c;
  logic           busy_c, app_c, match_c;

  rc_hash #(.WORD_W(W), .IDX_W(IW)) u_hash (
    .hi_i(ptr_hi_i), .lo_i(ptr_lo_i), .residue_o(res_c), .idx_o(idx_c)
  );

  rc_status_class #(.RC_W(RC_W)) u_class (
    .count_i(status_i[RC_MSB:RC_LSB]), .ovf_i(status_i[BIT_OVF]),
    .in_tbl_i(status_i[BIT_IN_TBL]), .stack_i(status_i[BIT_STACK]),
    .busy_o(busy_c), .need_append_o(app_c)
  );

  rc_entry_match #(.WORD_W(W)) u_match (
    .entry_i(tbl_data_i), .residue_i(res_q), .match_o(match_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stat_q  <= '0;
      res_q   <= '0;
      idx_q   <= '0;
      disp_q  <= DISP_CONT;
      chg_q   <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          stat_q <= status_i;
          res_q  <= res_c;
          idx_q  <= idx_c;
          disp_q <= DISP_CONT;
          chg_q  <= 1'b0;
          trap_q <= 1'b0;
          if (busy_c)     state_q <= ST_DONE;
          else if (app_c) state_q <= ST_APPEND;
          else            state_q <= ST_LOOKUP;
        end
        ST_LOOKUP:  state_q <= ST_COMPARE;
        ST_COMPARE: begin
          if (match_c) state_q <= ST_APPEND;
          else begin
            disp_q  <= stat_q[BIT_FINAL] ? DISP_FINAL : DISP_RECLAIM;
            state_q <= ST_DONE;
          end
        end
        ST_APPEND: if (app_ack_i) begin
          // full table: no status change, trap reported instead
          if (app_full_i) trap_q <= 1'b1;
          else begin
            chg_q             <= 1'b1;
            stat_q[BIT_IN_TBL] <= 1'b1;
          end
          disp_q  <= DISP_CONT;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tbl_rd_o    = (state_q == ST_LOOKUP);
    tbl_idx_o   = idx_q;
    app_req_o   = (state_q == ST_APPEND);
    done_o      = (state_q == ST_DONE);
    disp_o      = disp_q;
    changed_o   = chg_q;
    status_o    = stat_q;
    trap_o      = trap_q;
    trap_code_o = trap_q ? TRAP_FULL : 3'd0;
  end
endmodule

// File: rtl/reclaim_checker_chk.sv
module reclaim_checker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tbl_rd_o,
  input logic       app_req_o,
  input logic       app_ack_i,
  input logic       done_o,
  input logic [1:0] disp_o,
  input logic       changed_o,
  input logic [15:0] status_o,
  input logic       trap_o,
  input logic [2:0] trap_code_o
);
  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  disp_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> disp_o != 2'd3);
  // R4
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_rd_o |=> !tbl_rd_o);
  // R3
  changed_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && changed_o) |-> (disp_o == 2'd0 && status_o[15]));
  // R9
  full_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trap_o) |-> (trap_code_o == 3'd4 && !changed_o));
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_req_o && !app_ack_i) |=> app_req_o);
  // R11
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!done_o && !app_req_o && !tbl_rd_o));
endmodule

bind reclaim_checker reclaim_checker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tbl_rd_o(tbl_rd_o), .app_req_o(app_req_o),
  .app_ack_i(app_ack_i), .done_o(done_o), .disp_o(disp_o), .changed_o(changed_o),
  .status_o(status_o), .trap_o(trap_o), .trap_code_o(trap_code_o)
);

// File: tb/sim_reclaim_checker.sv
module sim_reclaim_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ptr_hi_i = '0, ptr_lo_i = '0, status_i = '0;
  logic        tbl_rd_o, app_req_o, done_o, changed_o, trap_o;
  logic [11:0] tbl_idx_o;
  logic [15:0] tbl_data_i, status_o;
  logic        app_ack_i;
  logic        app_full_i = 1'b0;
  logic [1:0]  disp_o;
  logic [2:0]  trap_code_o;

  int checks = 0, errors = 0;
  int rd_cnt = 0, app_cnt = 0, wait_cnt = 0, ack_delay = 0, lat = 0;
  logic [11:0] last_idx = '0;
  logic [15:0] mem [4096];

  always #4 clk_i = ~clk_i;

  reclaim_checker u0 (.*);

  initial tbl_data_i = '0;
  initial app_ack_i = 1'b0;

  always @(posedge clk_i) begin
    if (tbl_rd_o) begin
      tbl_data_i <= mem[tbl_idx_o];
      last_idx   <= tbl_idx_o;
      rd_cnt     <= rd_cnt + 1;
    end
    app_ack_i <= 1'b0;
    if (app_req_o && !app_ack_i) begin
      if (wait_cnt >= ack_delay) begin
        app_ack_i <= 1'b1;
        app_cnt   <= app_cnt + 1;
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_res(input logic [15:0] hi, input logic [15:0] lo);
    return 16'((32'(hi) * 8) | (32'(lo) / 8192));
  endfunction
  function automatic logic [11:0] f_idx(input logic [15:0] hi, input logic [15:0] lo);
    return 12'(((lo / 2) ^ f_res(hi, lo)) & 16'h0FFF);
  endfunction

  task automatic run_op(input logic [15:0] hi, input logic [15:0] lo, input logic [15:0] st);
    @(negedge clk_i);
    ptr_hi_i = hi; ptr_lo_i = lo; status_i = st; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R11 done", done_o, 0);
    chk("R11 rd", tbl_rd_o, 0);
    chk("R11 req", app_req_o, 0);
  endtask

  task automatic t_early(input logic [15:0] st, input string tag);
    int r0 = rd_cnt, a0 = app_cnt;
    run_op(16'h0123, 16'h4566, st);
    chk({tag, " disp"}, disp_o, 0);
    chk({tag, " changed"}, changed_o, 0);
    chk({tag, " status"}, status_o, st);
    chk({tag, " lat"}, lat, 0);
    chk({tag, " reads"}, rd_cnt - r0, 0);
    chk({tag, " appends"}, app_cnt - a0, 0);
  endtask

  task automatic t_stack();
    int r0 = rd_cnt, a0 = app_cnt;
    run_op(16'h0042, 16'h1000, 16'h4000);
    chk("R3 disp", disp_o, 0);
    chk("R3 changed", changed_o, 1);
    chk("R3 status", status_o, 16'hC000);
    chk("R3 reads", rd_cnt - r0, 0);
    chk("R3 appends", app_cnt - a0, 1);
  endtask

  task automatic t_lookup(input logic [15:0] hi, input logic [15:0] lo, input logic [15:0] st,
                          input logic [15:0] entry, input logic [1:0] exp_disp,
                          input logic exp_app, input string tag);
    int r0 = rd_cnt, a0 = app_cnt;
    logic [11:0] ix = f_idx(hi, lo);
    mem[ix] = entry;
    run_op(hi, lo, st);
    chk({tag, " R4 index"}, last_idx, ix);
    chk({tag, " R4 reads"}, rd_cnt - r0, 1);
    chk({tag, " R1 disp"}, disp_o, exp_disp);
    chk({tag, " appends"}, app_cnt - a0, exp_app);
    chk({tag, " changed"}, changed_o, exp_app);
    chk({tag, " status"}, status_o, exp_app ? (st | 16'h8000) : st);
    if (!exp_app) chk({tag, " R4 lat"}, lat, 2);
    mem[ix] = 16'h8000;
  endtask

  task automatic t_full();
    app_full_i = 1'b1;
    run_op(16'h0001, 16'h0000, 16'h4000);
    chk("R9 trap", trap_o, 1);
    chk("R9 code", trap_code_o, 4);
    chk("R9 changed", changed_o, 0);
    app_full_i = 1'b0;
  endtask

  task automatic t_delay();
    ack_delay = 3;
    run_op(16'h0002, 16'h0000, 16'h4000);
    chk("R10 lat", lat, 5);
    chk("R10 changed", changed_o, 1);
    ack_delay = 0;
    @(negedge clk_i);
    chk("R1 done one cycle", done_o, 0);
    chk("R1 result held", changed_o, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h8000;
    #1 t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_early(16'h0004, "R2 count");
    t_early(16'h0001, "R2 ovf");
    t_early(16'hC000, "R2 intbl priority");
    t_stack();
    // R7: empty entry, bit 7 clear -> reclaim
    t_lookup(16'h0ABC, 16'hE372, 16'h0000, 16'h8000, 2'd1, 1'b0, "R7");
    // R8: finalizable -> finalize
    t_lookup(16'h0FFF, 16'hFFFE, 16'h0080, 16'h8000, 2'd2, 1'b0, "R8");
    // R5: residue match
    t_lookup(16'h0ABC, 16'hE372, 16'h0080, f_res(16'h0ABC, 16'hE372), 2'd0, 1'b1, "R5");
    // R6: wildcard
    t_lookup(16'h0123, 16'h2468, 16'h0000, 16'hFFFF, 2'd0, 1'b1, "R6");
    // R7: near-miss residue
    t_lookup(16'h0777, 16'hA000, 16'h0000, f_res(16'h0777, 16'hA000) ^ 16'h0001, 2'd1, 1'b0, "R7 near");
    t_full();
    t_delay();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule